// File: doc/BRIEF.md
# Decade Clock Divider with Even-Duty Output

This block divides a fast input clock by ten. It steps a decimal digit through the values 0 to 9 and then back to 0, one step per input clock. The output of the block is a square wave at one tenth of the input frequency. A single toggle flop produces this wave, and it flips when the digit leaves 4 and again when the digit leaves 9. The result is five input clocks high followed by five input clocks low.

The top bit of the digit is also brought out unchanged. This gives a second signal at one tenth of the input rate, high for two of every ten clocks. Both outputs come straight from flops. They are intended as data-rate enables or as observation signals, and are not meant to drive a clock tree.

The digit is held as an enumerated state machine with ten states, DIG0 to DIG9. The transitions are DIG0→DIG1, DIG1→DIG2, DIG2→DIG3, DIG3→DIG4, DIG4→DIG5, DIG5→DIG6, DIG6→DIG7, DIG7→DIG8, DIG8→DIG9 and DIG9→DIG0. A recovery transition sends any of the six codes outside 0 to 9 to DIG0 on the next clock. A synchronous reset forces DIG0 and clears the square wave.

Top module: `bcd_div10_clkgen`

## Requirements
- R1: A clock edge with `rst_i` high sets the digit to 0, `square_o` to 0 and `msb_o` to 0, whatever the previous state.
- R2: With reset low, the digit advances by one on each clock edge from 0 up to 9, and 9 is followed by 0. Every output therefore repeats every 10 clocks.
- R3: `msb_o` is bit 3 of the digit. It is 1 only while the digit is 8 or 9, which gives 2 high clocks and 8 low clocks in each period of 10.
- R4: `square_o` changes from 0 to 1 on the same edge on which the digit moves from 4 to 5.
- R5: `square_o` changes from 1 to 0 on the same edge on which the digit moves from 9 to 0. On that same edge `msb_o` also falls.
- R6: After reset is released, `square_o` alternates between runs of exactly 5 clocks low and 5 clocks high.
- R7: Reset takes priority over a pending toggle. A reset edge taken while the digit is 4 or 9 leaves `square_o` at 0.
- R8: On the edge where `square_o` does not toggle, it holds its value. It toggles only when the digit is leaving 4 or leaving 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| square_o | output | 1 | Divide-by-ten square wave, 50% duty |
| msb_o | output | 1 | Top digit bit, divide-by-ten at 20% duty |

## Verification
Two events can fall on the same clock edge: the falling toggle of the square wave and the fall of the top digit bit. Both happen when the digit wraps from 9 to 0. A reset can also arrive on exactly the edge where a toggle is pending. The bench runs many uninterrupted periods, so that every wrap edge is compared against a behavioural model of both outputs. It then applies reset on the edges where the model's digit is 4 or 9 and checks that the square wave stays low and that the count starts again from 0. The lengths of the high and low runs on both outputs are measured independently of the per-clock comparison.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;

    localparam int DIGIT_W = 4;
    localparam int MODULUS = 10;
    localparam int RISE_AT = 4;              // digit left when square wave rises
    localparam int FALL_AT = MODULUS - 1;    // digit left when square wave falls
    localparam int MSB_IDX = DIGIT_W - 1;

    typedef enum logic [DIGIT_W-1:0] {
        DIG0 = 4'd0,
        DIG1 = 4'd1,
        DIG2 = 4'd2,
        DIG3 = 4'd3,
        DIG4 = 4'd4,
        DIG5 = 4'd5,
        DIG6 = 4'd6,
        DIG7 = 4'd7,
        DIG8 = 4'd8,
        DIG9 = 4'd9
    } digit_e;

endpackage

// File: rtl/bcd_div_digit_fsm.sv
module bcd_div_digit_fsm
    import bcd_div_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    output logic [DIGIT_W-1:0] digit_o,
    output logic               wrap_o
);

    digit_e state_q;
    digit_e state_d;

    // next-state decision
    always_comb begin
        unique case (state_q)
            DIG0:    state_d = DIG1;
            DIG1:    state_d = DIG2;
            DIG2:    state_d = DIG3;
            DIG3:    state_d = DIG4;
            DIG4:    state_d = DIG5;
            DIG5:    state_d = DIG6;
            DIG6:    state_d = DIG7;
            DIG7:    state_d = DIG8;
            DIG8:    state_d = DIG9;
            DIG9:    state_d = DIG0;
            default: state_d = DIG0;   // recovery from codes 10..15
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= DIG0;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        digit_o = state_q;
        wrap_o  = (state_q == DIG9);
    end

endmodule

// File: rtl/bcd_div_toggle_dec.sv
module bcd_div_toggle_dec
    import bcd_div_pkg::*;
#(
    parameter int RISE_DIGIT = RISE_AT,
    parameter int FALL_DIGIT = FALL_AT
) (
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               wrap_i,
    output logic               toggle_o
);

    localparam logic [DIGIT_W-1:0] RISE_CODE = DIGIT_W'(RISE_DIGIT);
    localparam logic [DIGIT_W-1:0] FALL_CODE = DIGIT_W'(FALL_DIGIT);

    logic hit_rise;
    logic hit_fall;

    generate
        if (FALL_DIGIT == MODULUS - 1) begin : g_fall_wrap
            // the falling point coincides with the wrap flag of the FSM
            assign hit_fall = wrap_i;
        end else begin : g_fall_dec
            assign hit_fall = (digit_i == FALL_CODE);
        end
    endgenerate

    assign hit_rise = (digit_i == RISE_CODE);
    assign toggle_o = hit_rise | hit_fall;

endmodule

// File: rtl/bcd_div_square_ff.sv
module bcd_div_square_ff (
    input  logic clk_i,
    input  logic rst_i,
    input  logic toggle_i,
    output logic square_o
);

    logic sq_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sq_q <= 1'b0;
        end else if (toggle_i) begin
            sq_q <= ~sq_q;
        end
    end

    assign square_o = sq_q;

endmodule

// File: rtl/bcd_div10_clkgen.sv
module bcd_div10_clkgen
    import bcd_div_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output logic square_o,
    output logic msb_o
);

    logic [DIGIT_W-1:0] digit_q;
    logic               wrap;
    logic               toggle;

    bcd_div_digit_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .digit_o (digit_q),
        .wrap_o  (wrap)
    );

    bcd_div_toggle_dec #(
        .RISE_DIGIT (RISE_AT),
        .FALL_DIGIT (FALL_AT)
    ) u_dec (
        .digit_i  (digit_q),
        .wrap_i   (wrap),
        .toggle_o (toggle)
    );

    bcd_div_square_ff u_sq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .toggle_i (toggle),
        .square_o (square_o)
    );

    assign msb_o = digit_q[MSB_IDX];

endmodule

// File: rtl/bcd_div10_checker.sv
module bcd_div10_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic [3:0] digit_i,
    input logic       square_i,
    input logic       msb_i
);

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        rst_i |=> (digit_i == 4'd0 && !square_i && !msb_i));

    assert_digit_legal_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        digit_i <= 4'd9);

    assert_digit_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (digit_i < 4'd9) |=> (digit_i == $past(digit_i) + 4'd1));

    assert_msb_rise_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(msb_i) |-> (digit_i == 4'd8));

    assert_square_rise_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (digit_i == 4'd4) |=> ($rose(square_i) && digit_i == 4'd5));

    assert_square_fall_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (digit_i == 4'd9) |=> ($fell(square_i) && $fell(msb_i) && digit_i == 4'd0));

    assert_square_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (digit_i != 4'd4 && digit_i != 4'd9) |=> $stable(square_i));

    assert_pending_reset_R7: assert property (@(posedge clk_i)
        (rst_i && (digit_i == 4'd4 || digit_i == 4'd9)) |=> !square_i);

endmodule

bind bcd_div10_clkgen bcd_div10_checker u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .digit_i  (digit_q),
    .square_i (square_o),
    .msb_i    (msb_o)
);

// File: tb/bcd_div10_clkgen_tb.sv
module bcd_div10_clkgen_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic square;
    logic msb;

    int tests  = 0;
    int fails  = 0;
    bit live   = 0;   // model valid once first reset edge taken

    // behavioural reference
    int m_cnt = 0;
    bit m_sq  = 0;

    // run-length tracking
    int  sq_run = 0, msb_run = 0;
    bit  sq_prev = 0, msb_prev = 0;
    int  sq_edges = 0, msb_edges = 0;
    bit  track = 0;

    always #4 clk = ~clk;   // 125 MHz

    bcd_div10_clkgen u_dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .square_o (square),
        .msb_o    (msb)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_sq  = 0;
            live  = 1;
        end else begin
            if (m_cnt == 4 || m_cnt == 9) m_sq = !m_sq;
            m_cnt = (m_cnt + 1) % 10;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            check("R2/R4/R5/R8 square", int'(square), int'(m_sq));
            check("R2/R3 msb", int'(msb), (m_cnt >= 8) ? 1 : 0);
        end
        if (track) begin
            if (square != sq_prev) begin
                if (sq_edges > 0) check("R6 run length", sq_run, 5);
                sq_edges++;
                sq_run = 1;
            end else sq_run++;
            if (msb != msb_prev) begin
                if (msb_edges > 0) check("R3 msb run", msb_run, msb_prev ? 2 : 8);
                msb_edges++;
                msb_run = 1;
            end else msb_run++;
            sq_prev  = square;
            msb_prev = msb;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 square after reset", int'(square), 0);
        check("R1 msb after reset", int'(msb), 0);
        rst = 1'b0;

        // free run with run-length measurement (R6, R3)
        sq_prev  = 1'b0;
        msb_prev = 1'b0;
        track    = 1;
        repeat (400) @(negedge clk);
        track = 0;
        check("R6 square edges seen", (sq_edges >= 70) ? 1 : 0, 1);
        check("R3 msb edges seen", (msb_edges >= 70) ? 1 : 0, 1);

        // R5: square and msb fall together on the wrap edge
        while (m_cnt != 9) @(negedge clk);
        check("R5 square high at 9", int'(square), 1);
        check("R5 msb high at 9", int'(msb), 1);
        @(negedge clk);
        check("R5 square low after wrap", int'(square), 0);
        check("R5 msb low after wrap", int'(msb), 0);

        // R7: reset on the edge where the rise toggle is pending
        while (m_cnt != 4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 square after reset at 4", int'(square), 0);
        repeat (5) @(negedge clk);
        check("R7 square rises 5 clocks later", int'(square), 1);

        // R7: reset on the edge where the fall toggle is pending
        while (m_cnt != 9) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 square after reset at 9", int'(square), 0);
        check("R1 msb after reset at 9", int'(msb), 0);
        repeat (4) @(negedge clk);   // reset held several clocks
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 square still low at digit 4", int'(square), 0);
        @(negedge clk);
        check("R4 square high at digit 5", int'(square), 1);

        repeat (60) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule